// File: doc/BRIEF.md
# Strobe-Framed Serial Command Decoder

This block is the host-facing front end of a display controller. A microcontroller talks to it over three wires: a serial clock, a frame strobe and a data line, plus one return line. Every frame opens with the strobe going low. The first byte of the frame is an instruction. The bytes after it are either display data, which the block writes into an external display RAM, or clock periods during which it shifts key-scan bytes back to the host. The serial pins are oversampled in the system clock domain. The system clock must run at least four times faster than the serial clock.

The block decodes four instruction classes: display mode, data setting, display control and address set. It keeps the current mode, dimming code, display enable and test flag on a configuration bus for the rest of the controller. It also holds the RAM address pointer, which either steps forward after each write or stays fixed. The return line is modelled as an open-drain pin: there is a value output, and an active-low enable that pulls the wire low only for a zero bit.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While the strobe is low, a data bit is taken on each rising serial-clock edge, least significant bit first. The first complete byte after the strobe falls is decoded as an instruction, and every later byte in that frame is a data byte.
- R2: When the strobe rises before eight bits have arrived, the partial byte is discarded, and the next frame starts with a new instruction byte. Serial-clock edges while the strobe is high have no effect.
- R3: Instruction bits 7:6 select the class. 00 is mode set, with the mode in bits 3:0. 01 is data setting. 10 is display control, with the dimming code in bits 2:0 and display enable in bit 3. 11 is address set, with the address in bits 4:0, and it is accepted only when bit 5 is 0. The configuration outputs change only when an instruction byte completes.
- R4: After reset, the address pointer is 0, all data-setting fields are 0, the mode is 0110, the dimming code is 000, the display is off, and the return line is released (value 1, enable 1).
- R5: When data-setting bits 1:0 are 00, each data byte produces exactly one RAM write pulse at the current address. When bit 2 is 0, the address then advances by one.
- R6: When data-setting bit 2 is 1, every data byte is written to the same address.
- R7: Only addresses 0x00 to 0x1D are valid. Data bytes received while the pointer holds 0x1E or above are dropped. This includes the pointer reached by incrementing past 0x1D, and it lasts until a valid address is set.
- R8: A data-setting instruction with bits 1:0 equal to 01 or 10 starts a read. On each later falling serial-clock edge, the next key bit is driven, LSB first, starting with key byte 0. Key byte n is requested on `key_idx_o` = n. Data bytes are not written during a read, or in later frames while the read mode is still selected.
- R9: On each falling edge after all key bytes have been sent, the return line is released, and it is also released whenever the strobe is high. While the line is not released, the enable is low exactly when the bit is 0.
- R10: A mode-set instruction that carries a different mode stores it and turns the display off. One that carries the current mode changes nothing.
- R11: Data-setting bit 3 is presented as the test-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, idles high |
| ser_stb_i | input | 1 | Frame strobe, active low |
| ser_din_i | input | 1 | Serial data from the host |
| ser_dout_o | output | 1 | Serial return bit value (1 when released) |
| ser_dout_oe_n_o | output | 1 | Active-low pull-down enable for the return line |
| ram_we_o | output | 1 | Display RAM write strobe, one cycle per byte |
| ram_addr_o | output | ADDR_W | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |
| key_idx_o | output | $clog2(KEY_BYTES) | Index of the key byte being shifted out |
| key_byte_i | input | 8 | Key byte selected by key_idx_o |
| cfg_mode_o | output | 4 | Current display mode |
| cfg_dim_o | output | 3 | Dimming code |
| cfg_disp_on_o | output | 1 | Display enable |
| cfg_test_o | output | 1 | Test-mode flag |

## Verification
The bound checker watches several properties on every cycle:
- Writes never reach an address above 0x1D, and each write strobe lasts one cycle.
- The configuration holds steady between instruction bytes.
- A mode change always leaves the display off.
- The return line moves only after a falling serial edge or a high strobe, and it is released once the strobe has been high long enough.

The scenario bench is the only way to show the rest:
- the bit order and instruction/data split of received bytes, and the address sequence under stepping and fixed addressing;
- that out-of-range and aborted bytes are discarded;
- that serial edges are ignored while the strobe is high;
- the exact key bits returned in each read clock period.

// File: rtl/scd_pkg.sv
package scd_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DATA = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_cls_e;

  typedef enum logic [1:0] {
    RW_WRITE = 2'b00,
    RW_KEY_A = 2'b01,
    RW_KEY_B = 2'b10,
    RW_NONE  = 2'b11
  } rw_sel_e;

endpackage

// File: rtl/scd_pin_sync.sv
// Synchronises the three serial pins and derives serial clock edges.
module scd_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_pin,
  input  logic stb_pin,
  input  logic din_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic stb_lvl,
  output logic din_lvl
);

  localparam int unsigned NPINS = 3;

  logic [NPINS-1:0] pins;
  logic [NPINS-1:0] lvl;
  logic             sclk_prev;

  assign pins = {din_pin, stb_pin, sclk_pin};

  // Reset values match the idle bus: clock high, strobe high, data low.
  localparam logic [NPINS-1:0] IDLE = 3'b011;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{IDLE[p]}};
      else     pipe <= {pipe[STAGES-2:0], pins[p]};
    end
    assign lvl[p] = pipe[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b1;
    else     sclk_prev <= lvl[0];
  end

  assign sclk_rise = lvl[0] & ~sclk_prev;
  assign sclk_fall = ~lvl[0] & sclk_prev;
  assign stb_lvl   = lvl[1];
  assign din_lvl   = lvl[2];

endmodule

// File: rtl/scd_byte_rx.sv
// Assembles LSB-first bytes and tags the first byte of a frame.
module scd_byte_rx #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb_lvl,
  input  logic            sclk_rise,
  input  logic            din_lvl,
  output logic            byte_vld,
  output logic            byte_is_cmd,
  output logic [BITS-1:0] byte_data
);

  localparam int unsigned CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;
  logic             first_q;

  always_ff @(posedge clk) begin
    if (rst || stb_lvl) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      first_q     <= 1'b1;
      byte_vld    <= 1'b0;
      byte_is_cmd <= 1'b0;
      byte_data   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (sclk_rise) begin
        sh_q  <= {din_lvl, sh_q[BITS-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST_BIT) begin
          byte_vld    <= 1'b1;
          byte_data   <= {din_lvl, sh_q[BITS-1:1]};
          byte_is_cmd <= first_q;
          first_q     <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/scd_cmd_core.sv
// Instruction decode, configuration state, address pointer, RAM writes.
module scd_cmd_core
  import scd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned LAST_ADDR  = 29,
  parameter int unsigned MODE_W     = 4,
  parameter int unsigned DIM_W      = 3,
  parameter logic [3:0]  RESET_MODE = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_lvl,
  input  logic              byte_vld,
  input  logic              byte_is_cmd,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              read_start,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [MODE_W-1:0] mode,
  output logic [DIM_W-1:0]  dim,
  output logic              disp_on,
  output logic              test_mode
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  cmd_cls_e          cls;
  rw_sel_e           rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fixed_q;
  logic              rd_frame_q;
  logic              addr_ok;
  logic              key_sel;

  assign cls     = cmd_cls_e'(byte_data[7:6]);
  assign addr_ok = (addr_q <= LAST_A);
  assign key_sel = (byte_data[1:0] == RW_KEY_A) || (byte_data[1:0] == RW_KEY_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q       <= RW_WRITE;
      addr_q     <= '0;
      fixed_q    <= 1'b0;
      test_mode  <= 1'b0;
      rd_frame_q <= 1'b0;
      read_start <= 1'b0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      mode       <= MODE_W'(RESET_MODE);
      dim        <= '0;
      disp_on    <= 1'b0;
    end else begin
      ram_we     <= 1'b0;
      read_start <= 1'b0;
      if (stb_lvl) rd_frame_q <= 1'b0;
      if (byte_vld) begin
        if (byte_is_cmd) begin
          unique case (cls)
            CLS_MODE: begin
              if (byte_data[MODE_W-1:0] != mode) begin
                mode    <= byte_data[MODE_W-1:0];
                disp_on <= 1'b0;
              end
            end
            CLS_DATA: begin
              rw_q      <= rw_sel_e'(byte_data[1:0]);
              fixed_q   <= byte_data[2];
              test_mode <= byte_data[3];
              if (key_sel) begin
                rd_frame_q <= 1'b1;
                read_start <= 1'b1;
              end
            end
            CLS_CTRL: begin
              dim     <= byte_data[DIM_W-1:0];
              disp_on <= byte_data[3];
            end
            CLS_ADDR: begin
              if (!byte_data[5]) addr_q <= byte_data[ADDR_W-1:0];
            end
          endcase
        end else if (!rd_frame_q && rw_q == RW_WRITE && addr_ok) begin
          ram_we    <= 1'b1;
          ram_addr  <= addr_q;
          ram_wdata <= byte_data;
          if (!fixed_q) addr_q <= addr_q + ADDR_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/scd_key_tx.sv
// Shifts key bytes out LSB first on falling serial clock edges.
module scd_key_tx #(
  parameter int unsigned KEY_BYTES = 4,
  parameter int unsigned BITS      = 8,
  localparam int unsigned KIDX_W   = $clog2(KEY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_lvl,
  input  logic              sclk_fall,
  input  logic              read_start,
  input  logic [BITS-1:0]   key_byte,
  output logic [KIDX_W-1:0] key_idx,
  output logic              dout
);

  localparam int unsigned IDX_W = $clog2(KEY_BYTES + 1);
  localparam int unsigned BIT_W = $clog2(BITS);
  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(KEY_BYTES);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

  logic             active_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || stb_lvl) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      idx_q    <= '0;
      dout     <= 1'b1;
    end else if (read_start) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      idx_q    <= '0;
    end else if (active_q && sclk_fall) begin
      if (idx_q == DONE_IDX) begin
        dout     <= 1'b1;
        active_q <= 1'b0;
      end else begin
        dout  <= key_byte[bit_q];
        bit_q <= bit_q + BIT_W'(1);
        if (bit_q == LAST_BIT) idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign key_idx = idx_q[KIDX_W-1:0];

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import scd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned LAST_ADDR   = 29,
  parameter int unsigned KEY_BYTES   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned DIM_W       = 3,
  parameter logic [3:0]  RESET_MODE  = 4'b0110,
  localparam int unsigned KIDX_W     = $clog2(KEY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_stb_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic              ser_dout_oe_n_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic [KIDX_W-1:0] key_idx_o,
  input  logic [7:0]        key_byte_i,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic [DIM_W-1:0]  cfg_dim_o,
  output logic              cfg_disp_on_o,
  output logic              cfg_test_o
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              stb_lvl;
  logic              din_lvl;
  logic              rx_vld;
  logic              rx_is_cmd;
  logic [BYTE_W-1:0] rx_data;
  logic              read_start;
  logic              dout_bit;

  scd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_pin  (ser_clk_i),
    .stb_pin   (ser_stb_i),
    .din_pin   (ser_din_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .stb_lvl   (stb_lvl),
    .din_lvl   (din_lvl)
  );

  scd_byte_rx #(.BITS(BYTE_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .stb_lvl     (stb_lvl),
    .sclk_rise   (sclk_rise),
    .din_lvl     (din_lvl),
    .byte_vld    (rx_vld),
    .byte_is_cmd (rx_is_cmd),
    .byte_data   (rx_data)
  );

  scd_cmd_core #(
    .ADDR_W     (ADDR_W),
    .LAST_ADDR  (LAST_ADDR),
    .MODE_W     (MODE_W),
    .DIM_W      (DIM_W),
    .RESET_MODE (RESET_MODE)
  ) u_core (
    .clk         (clk),
    .rst         (rst),
    .stb_lvl     (stb_lvl),
    .byte_vld    (rx_vld),
    .byte_is_cmd (rx_is_cmd),
    .byte_data   (rx_data),
    .read_start  (read_start),
    .ram_we      (ram_we_o),
    .ram_addr    (ram_addr_o),
    .ram_wdata   (ram_wdata_o),
    .mode        (cfg_mode_o),
    .dim         (cfg_dim_o),
    .disp_on     (cfg_disp_on_o),
    .test_mode   (cfg_test_o)
  );

  scd_key_tx #(.KEY_BYTES(KEY_BYTES), .BITS(BYTE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .stb_lvl    (stb_lvl),
    .sclk_fall  (sclk_fall),
    .read_start (read_start),
    .key_byte   (key_byte_i),
    .key_idx    (key_idx_o),
    .dout       (dout_bit)
  );

  // Open drain: pull low only for a zero bit; a released line reads as 1.
  assign ser_dout_o      = dout_bit;
  assign ser_dout_oe_n_o = dout_bit;

endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned LAST_ADDR = 29,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned DIM_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_stb_i,
  input logic              ser_dout_o,
  input logic              ser_dout_oe_n_o,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [MODE_W-1:0] cfg_mode_o,
  input logic [DIM_W-1:0]  cfg_dim_o,
  input logic              cfg_disp_on_o,
  input logic              rx_vld,
  input logic              sclk_fall,
  input logic              stb_lvl
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  assert_we_addr_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> (ram_addr_o <= LAST_A));

  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |=> !ram_we_o);

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_vld) |-> ($stable(cfg_dim_o) && $stable(cfg_disp_on_o) && $stable(cfg_mode_o)));

  assert_mode_off_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_mode_o) != cfg_mode_o) |-> !cfg_disp_on_o);

  assert_dout_edge_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_dout_o) |-> ($past(sclk_fall) || $past(stb_lvl)));

  assert_release_stb_R9: assert property (@(posedge clk) disable iff (rst)
    (ser_stb_i && $past(ser_stb_i) && $past(ser_stb_i, 2) && $past(ser_stb_i, 3))
      |-> ser_dout_oe_n_o);

endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .LAST_ADDR (LAST_ADDR),
  .MODE_W    (MODE_W),
  .DIM_W     (DIM_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .ser_stb_i       (ser_stb_i),
  .ser_dout_o      (ser_dout_o),
  .ser_dout_oe_n_o (ser_dout_oe_n_o),
  .ram_we_o        (ram_we_o),
  .ram_addr_o      (ram_addr_o),
  .cfg_mode_o      (cfg_mode_o),
  .cfg_dim_o       (cfg_dim_o),
  .cfg_disp_on_o   (cfg_disp_on_o),
  .rx_vld          (rx_vld),
  .sclk_fall       (sclk_fall),
  .stb_lvl         (stb_lvl)
);

// File: tb/serial_cmd_decoder_tb_top.sv
module serial_cmd_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 100000;
  localparam int ADDR_W     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic stb = 1'b1;
  logic din = 1'b0;
  logic dout, dout_oe_n, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [1:0] key_idx;
  logic [7:0] key_byte;
  logic [3:0] cfg_mode;
  logic [2:0] cfg_dim;
  logic cfg_on, cfg_test;

  logic [7:0] keys [4];
  assign key_byte = keys[key_idx];

  int n_chk = 0;
  int n_err = 0;
  logic [12:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_decoder dut_i (
    .clk(clk), .rst(rst),
    .ser_clk_i(sclk), .ser_stb_i(stb), .ser_din_i(din),
    .ser_dout_o(dout), .ser_dout_oe_n_o(dout_oe_n),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .key_idx_o(key_idx), .key_byte_i(key_byte),
    .cfg_mode_o(cfg_mode), .cfg_dim_o(cfg_dim),
    .cfg_disp_on_o(cfg_on), .cfg_test_o(cfg_test)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wr(input logic [4:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // Scoreboard monitor: every RAM write must match the next expected one.
  always @(negedge clk) begin
    if (!rst && ram_we) begin
      if (exp_q.size() == 0) begin
        chk("R5/R7 unexpected write", {19'd0, ram_addr, ram_wdata}, 32'hFFFF);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk("R5 write address", {27'd0, ram_addr}, {27'd0, e[12:8]});
        chk("R5 write data", {24'd0, ram_wdata}, {24'd0, e[7:0]});
      end
    end
  end

  task automatic open_frame();
    stb = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic close_frame();
    stb = 1'b1;
    wait_cyc(2 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = b[i];
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
    end
  endtask

  task automatic frame1(input logic [7:0] c);
    open_frame(); send_bits(c, 8); close_frame();
  endtask

  task automatic read_key(input string req, input logic [7:0] exp_b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      wait_cyc(HALF);
      chk({req, " key bit"}, {31'd0, dout}, {31'd0, exp_b[i]});
      chk("R9 enable low only for zero", {31'd0, dout_oe_n}, {31'd0, exp_b[i]});
      sclk = 1'b1;
      wait_cyc(HALF);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    keys[0] = 8'hA5; keys[1] = 8'h3C; keys[2] = 8'h81; keys[3] = 8'h7E;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(4);

    // R4 reset state
    chk("R4 mode", {28'd0, cfg_mode}, 32'h6);
    chk("R4 dim", {29'd0, cfg_dim}, 32'h0);
    chk("R4 display off", {31'd0, cfg_on}, 32'h0);
    chk("R4 test flag", {31'd0, cfg_test}, 32'h0);
    chk("R4 line released", {30'd0, dout, dout_oe_n}, 32'h3);

    // R1 R5: reset pointer 0, stepping writes; data bytes after command
    expect_wr(5'd0, 8'hAA); expect_wr(5'd1, 8'h55);
    open_frame(); send_bits(8'h40, 8); send_bits(8'hAA, 8); send_bits(8'h55, 8); close_frame();
    expect_wr(5'd2, 8'h0F);
    open_frame(); send_bits(8'hC2, 8); send_bits(8'h0F, 8); close_frame();
    chk("R1 R5 queue drained", exp_q.size(), 0);

    // R6 fixed address
    frame1(8'h44);
    expect_wr(5'd5, 8'h11); expect_wr(5'd5, 8'h22);
    open_frame(); send_bits(8'hC5, 8); send_bits(8'h11, 8); send_bits(8'h22, 8); close_frame();
    chk("R6 queue drained", exp_q.size(), 0);

    // R7 invalid address and stepping past the last valid address
    frame1(8'h40);
    open_frame(); send_bits(8'hDE, 8); send_bits(8'h33, 8); close_frame();
    expect_wr(5'd29, 8'h77);
    open_frame(); send_bits(8'hDD, 8); send_bits(8'h77, 8); send_bits(8'h88, 8); close_frame();
    open_frame(); send_bits(8'h99, 8); close_frame();
    chk("R7 queue drained", exp_q.size(), 0);
    // R3 address set with bit 5 high is ignored: pointer stays invalid (0x1E)
    open_frame(); send_bits(8'hE3, 8); send_bits(8'h44, 8); close_frame();
    chk("R3 addr bit5 ignored", exp_q.size(), 0);

    // R3 display control
    frame1(8'h8B);
    chk("R3 dim code", {29'd0, cfg_dim}, 32'h3);
    chk("R3 display on", {31'd0, cfg_on}, 32'h1);

    // R10 same mode keeps display, new mode turns it off
    frame1(8'h06);
    chk("R10 same mode keeps on", {31'd0, cfg_on}, 32'h1);
    frame1(8'h03);
    chk("R10 new mode stored", {28'd0, cfg_mode}, 32'h3);
    chk("R10 new mode turns off", {31'd0, cfg_on}, 32'h0);
    frame1(8'h8F);

    // R2 partial byte discarded
    open_frame(); send_bits(8'hFF, 3); close_frame();
    frame1(8'h8A);
    chk("R2 after abort dim", {29'd0, cfg_dim}, 32'h2);
    chk("R2 after abort on", {31'd0, cfg_on}, 32'h1);

    // R2 clock ignored with strobe high
    din = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; wait_cyc(HALF); sclk = 1'b1; wait_cyc(HALF);
    end
    frame1(8'h8D);
    chk("R2 idle clocks ignored dim", {29'd0, cfg_dim}, 32'h5);

    // R11 test flag
    frame1(8'h48);
    chk("R11 test set", {31'd0, cfg_test}, 32'h1);
    frame1(8'h40);
    chk("R11 test clear", {31'd0, cfg_test}, 32'h0);

    // R8 R9 key read, mode 01
    open_frame();
    send_bits(8'h41, 8);
    chk("R9 released before first read clock", {31'd0, dout_oe_n}, 32'h1);
    read_key("R8 byte0", keys[0]);
    read_key("R8 byte1", keys[1]);
    read_key("R8 byte2", keys[2]);
    read_key("R8 byte3", keys[3]);
    sclk = 1'b0; wait_cyc(HALF);
    chk("R9 released after last key", {30'd0, dout, dout_oe_n}, 32'h3);
    sclk = 1'b1; wait_cyc(HALF);
    close_frame();

    // R8 mode 10 restarts from key byte 0; release on strobe
    keys[0] = 8'h5A;
    open_frame();
    send_bits(8'h42, 8);
    read_key("R8 mode10 byte0", keys[0]);
    close_frame();
    chk("R9 released on strobe high", {30'd0, dout, dout_oe_n}, 32'h3);

    // R8 no writes while read mode remains selected
    open_frame(); send_bits(8'hC0, 8); send_bits(8'h12, 8); close_frame();
    chk("R8 no write in read mode", exp_q.size(), 0);
    frame1(8'h40);
    expect_wr(5'd2, 8'h12);
    open_frame(); send_bits(8'hC2, 8); send_bits(8'h12, 8); close_frame();
    chk("R5 write resumes", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule